// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard and Interlock Controller

This block is the hazard-control unit for an in-order pipeline with six stages: fetch, decode (ID), execute (EX), two memory stages (M1, M2) and writeback (WB). ALU instructions commit their result to the register file at the end of EX through a second write port. Loads commit in WB. The unit inspects the instruction in each stage: its valid bit, its class (none, ALU, load, store) and its destination register. It also inspects the source registers of the instruction in ID. From these it decides whether decode must stall. It picks the operand bypass for each source and, when M2 reports an address fault, squashes every younger instruction.

Because an ALU result retires at the end of EX, a fault found in M2 would otherwise arrive after a younger ALU instruction had already changed the register file. The unit therefore holds any ALU instruction that sits directly behind a load or store for one cycle. It also masks the EX-stage write port while a fault is being reported. Producers in M1 or later are already visible in the register file, except loads. A load needs a stall while it is in EX or M1, and a bypass from M2 or WB after that.

Most outputs are combinational in the current stage contents. The trap flag is a registered pulse.

Top module: `hazard_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `trap_o` is 0.
- R2: When the youngest valid producer whose destination matches a nonzero ID source is an ALU instruction in EX, that source's bypass select is 1 (EX result).
- R3: When the youngest matching producer is an ALU instruction in M1, M2 or WB, or when nothing matches, the select is 0 (register file).
- R4: When the youngest matching producer is a load, the select is 2 if the load is in M2 and 3 if it is in WB.
- R5: A valid ID instruction of any class stalls when, for any of its nonzero sources, the youngest matching producer is a load in EX or M1.
- R6: A valid ALU-class instruction in ID stalls whenever EX holds a valid load or store, whatever its sources are. Non-ALU ID instructions are not stalled by this rule.
- R7: Register 0 never creates a dependence. A source of 0 always selects 0 and never causes a load-use stall, and a destination of 0 matches no source.
- R8: Only the youngest matching producer decides a source's select and load-use stall. The age order, youngest first, is EX, M1, M2, WB. Store-class, none-class and invalid stages are never producers.
- R9: In a cycle where M2 is valid with an address fault, `flush_o` is 4'b1111 (bit 0 = IF, bit 1 = ID, bit 2 = EX, bit 3 = M1), `stall_o` is 0 and `ex_rf_we_o` is 0. Otherwise `flush_o` is 0.
- R10: `trap_o` is 1 in exactly the cycle after a cycle with a valid faulting M2 instruction, and 0 otherwise.
- R11: `ex_rf_we_o` is 1 exactly when EX holds a valid ALU instruction with a nonzero destination and no M2 fault is reported.
- R12: `stall_o` is 0 when the ID instruction is invalid. `stall_o` means "freeze IF and ID and place a bubble into EX".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid_i | input | 1 | ID instruction valid |
| id_cls_i | input | 2 | ID class: 0 none, 1 ALU, 2 load, 3 store |
| id_src_i | input | NSRC*REG_W | ID source registers, source 0 in the low bits |
| ex_valid_i | input | 1 | EX valid |
| ex_cls_i | input | 2 | EX class |
| ex_dst_i | input | REG_W | EX destination |
| m1_valid_i | input | 1 | M1 valid |
| m1_cls_i | input | 2 | M1 class |
| m1_dst_i | input | REG_W | M1 destination |
| m2_valid_i | input | 1 | M2 valid |
| m2_cls_i | input | 2 | M2 class |
| m2_dst_i | input | REG_W | M2 destination |
| m2_exc_i | input | 1 | M2 address fault |
| wb_valid_i | input | 1 | WB valid |
| wb_cls_i | input | 2 | WB class |
| wb_dst_i | input | REG_W | WB destination |
| stall_o | output | 1 | Freeze IF/ID, bubble into EX |
| fwd_sel_o | output | NSRC*2 | Per-source bypass select: 0 RF, 1 EX, 2 M2, 3 WB |
| ex_rf_we_o | output | 1 | Enable for the EX-stage write port |
| flush_o | output | 4 | Squash IF, ID, EX, M1 (bits 0..3) |
| trap_o | output | 1 | Registered fault pulse |

## Verification
The bench sweeps every combination of valid, class and a 2-bit destination for EX and M1. It crosses these with every ID class and every value of the first source. M2, WB, the second source, the ID valid bit and the fault input vary pseudo-randomly. This separates the youngest-producer choice from older matches, ALU retirement at EX from load retirement in WB, and the dependence-free memory-after stall from the load-use stall. Directed cases pin the register-0 exemption, the squash cycle with its masked write, and the one-cycle placement of the trap pulse.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard controller.
// Assumes a 2-bit class tag and a 2-bit bypass select on all interfaces.
package hz_pkg;
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } icls_e;

    typedef enum logic [1:0] {
        FWD_RF = 2'd0,
        FWD_EX = 2'd1,
        FWD_M2 = 2'd2,
        FWD_WB = 2'd3
    } fwd_e;

    localparam int NPROD    = 4;  // producer stages EX, M1, M2, WB
    localparam int NFLUSH   = 4;  // squashable stages IF, ID, EX, M1
    localparam int FWD_W    = 2;
endpackage

// File: rtl/hz_src_resolve.sv
// Resolves one ID source against the producer stages.
// Finds the youngest valid ALU/load producer with a matching nonzero
// destination and yields its bypass select and whether it forces a
// load-use stall. Index 0 of the producer arrays is EX (youngest), 3 is WB.
module hz_src_resolve
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic             prod_valid_i [NPROD],
    input  logic [1:0]       prod_cls_i   [NPROD],
    input  logic [REG_W-1:0] prod_dst_i   [NPROD],
    output logic [FWD_W-1:0] sel_o,
    output logic             load_use_o
);
    logic [NPROD-1:0] hit;

    // Per-stage match: valid producer class, nonzero register, equal index.
    always_comb begin
        for (int i = 0; i < NPROD; i++) begin
            hit[i] = prod_valid_i[i]
                  && (prod_cls_i[i] == CLS_ALU || prod_cls_i[i] == CLS_LOAD)
                  && (src_i != '0)
                  && (prod_dst_i[i] == src_i);
        end
    end

    // Walk oldest to youngest so the youngest hit sets the final answer.
    always_comb begin
        sel_o      = FWD_RF;
        load_use_o = 1'b0;
        for (int i = NPROD - 1; i >= 0; i--) begin
            if (hit[i]) begin
                if (prod_cls_i[i] == CLS_ALU) begin
                    sel_o      = (i == 0) ? FWD_EX : FWD_RF;
                    load_use_o = 1'b0;
                end else begin
                    sel_o      = (i == 2) ? FWD_M2 : ((i == 3) ? FWD_WB : FWD_RF);
                    load_use_o = (i <= 1);
                end
            end
        end
    end
endmodule

// File: rtl/hz_interlock.sv
// Combines the load-use stall of every source with the memory-after
// interlock (ALU in ID behind a load/store in EX). A reported M2 fault
// overrides any stall because the younger stages are being squashed.
module hz_interlock
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            id_valid_i,
    input  logic [1:0]      id_cls_i,
    input  logic [NSRC-1:0] load_use_i,
    input  logic            ex_valid_i,
    input  logic [1:0]      ex_cls_i,
    input  logic            fault_i,
    output logic            stall_o
);
    logic mem_in_ex;
    logic mem_after;

    // Memory-after rule: independent of operand dependences.
    always_comb begin
        mem_in_ex = ex_valid_i && (ex_cls_i == CLS_LOAD || ex_cls_i == CLS_STORE);
        mem_after = (id_cls_i == CLS_ALU) && mem_in_ex;
    end

    // Final stall decision.
    always_comb begin
        stall_o = id_valid_i && !fault_i && (mem_after || (|load_use_i));
    end
endmodule

// File: rtl/hz_squash.sv
// Precise-exception control: squashes younger stages on an M2 fault,
// masks the EX-stage write port in that cycle and registers a trap pulse.
// Assumes the fault input is meaningful only with a valid M2 instruction.
module hz_squash
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2_valid_i,
    input  logic              m2_exc_i,
    input  logic              ex_valid_i,
    input  logic [1:0]        ex_cls_i,
    input  logic [REG_W-1:0]  ex_dst_i,
    output logic              fault_o,
    output logic [NFLUSH-1:0] flush_o,
    output logic              ex_rf_we_o,
    output logic              trap_o
);
    // Fault detection and squash fan-out.
    always_comb begin
        fault_o = m2_valid_i && m2_exc_i;
        flush_o = {NFLUSH{fault_o}};
    end

    // EX write port enable, blocked while an older fault is reported.
    always_comb begin
        ex_rf_we_o = ex_valid_i && (ex_cls_i == CLS_ALU)
                  && (ex_dst_i != '0) && !fault_o;
    end

    // One-cycle trap pulse following the fault cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_o <= 1'b0;
        else        trap_o <= fault_o;
    end
endmodule

// File: rtl/hazard_ctl.sv
// Top of the six-stage hazard controller.
// Gathers the producer stages into arrays, resolves each ID source in its
// own resolver, and feeds the interlock and squash logic. Outputs other
// than trap_o are combinational in the current stage contents.
module hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  id_valid_i,
    input  logic [1:0]            id_cls_i,
    input  logic [NSRC*REG_W-1:0] id_src_i,
    input  logic                  ex_valid_i,
    input  logic [1:0]            ex_cls_i,
    input  logic [REG_W-1:0]      ex_dst_i,
    input  logic                  m1_valid_i,
    input  logic [1:0]            m1_cls_i,
    input  logic [REG_W-1:0]      m1_dst_i,
    input  logic                  m2_valid_i,
    input  logic [1:0]            m2_cls_i,
    input  logic [REG_W-1:0]      m2_dst_i,
    input  logic                  m2_exc_i,
    input  logic                  wb_valid_i,
    input  logic [1:0]            wb_cls_i,
    input  logic [REG_W-1:0]      wb_dst_i,
    output logic                  stall_o,
    output logic [NSRC*FWD_W-1:0] fwd_sel_o,
    output logic                  ex_rf_we_o,
    output logic [NFLUSH-1:0]     flush_o,
    output logic                  trap_o
);
    logic             prod_valid [NPROD];
    logic [1:0]       prod_cls   [NPROD];
    logic [REG_W-1:0] prod_dst   [NPROD];
    logic [NSRC-1:0]  load_use;
    logic             fault;

    // Producer arrays ordered youngest (EX) to oldest (WB).
    always_comb begin
        prod_valid[0] = ex_valid_i;  prod_cls[0] = ex_cls_i;  prod_dst[0] = ex_dst_i;
        prod_valid[1] = m1_valid_i;  prod_cls[1] = m1_cls_i;  prod_dst[1] = m1_dst_i;
        prod_valid[2] = m2_valid_i;  prod_cls[2] = m2_cls_i;  prod_dst[2] = m2_dst_i;
        prod_valid[3] = wb_valid_i;  prod_cls[3] = wb_cls_i;  prod_dst[3] = wb_dst_i;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hz_src_resolve #(.REG_W(REG_W)) u_res (
            .src_i        (id_src_i[s*REG_W +: REG_W]),
            .prod_valid_i (prod_valid),
            .prod_cls_i   (prod_cls),
            .prod_dst_i   (prod_dst),
            .sel_o        (fwd_sel_o[s*FWD_W +: FWD_W]),
            .load_use_o   (load_use[s])
        );
    end

    hz_squash #(.REG_W(REG_W)) u_squash (
        .clk        (clk),
        .rst_n      (rst_n),
        .m2_valid_i (m2_valid_i),
        .m2_exc_i   (m2_exc_i),
        .ex_valid_i (ex_valid_i),
        .ex_cls_i   (ex_cls_i),
        .ex_dst_i   (ex_dst_i),
        .fault_o    (fault),
        .flush_o    (flush_o),
        .ex_rf_we_o (ex_rf_we_o),
        .trap_o     (trap_o)
    );

    hz_interlock #(.NSRC(NSRC)) u_lock (
        .id_valid_i (id_valid_i),
        .id_cls_i   (id_cls_i),
        .load_use_i (load_use),
        .ex_valid_i (ex_valid_i),
        .ex_cls_i   (ex_cls_i),
        .fault_i    (fault),
        .stall_o    (stall_o)
    );

    // Stages M1..WB class inputs feed the resolvers; m2_cls/wb_cls are used there.
endmodule

// File: rtl/hazard_ctl_chk.sv
// Property checker for hazard_ctl, bound to every instance of it.
// Observes only the top-level ports.
module hazard_ctl_chk #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  id_valid_i,
    input logic [1:0]            id_cls_i,
    input logic [NSRC*REG_W-1:0] id_src_i,
    input logic                  ex_valid_i,
    input logic [1:0]            ex_cls_i,
    input logic [REG_W-1:0]      ex_dst_i,
    input logic                  m1_valid_i,
    input logic [1:0]            m1_cls_i,
    input logic [REG_W-1:0]      m1_dst_i,
    input logic                  m2_valid_i,
    input logic [1:0]            m2_cls_i,
    input logic [REG_W-1:0]      m2_dst_i,
    input logic                  m2_exc_i,
    input logic                  wb_valid_i,
    input logic [1:0]            wb_cls_i,
    input logic [REG_W-1:0]      wb_dst_i,
    input logic                  stall_o,
    input logic [NSRC*2-1:0]     fwd_sel_o,
    input logic                  ex_rf_we_o,
    input logic [3:0]            flush_o,
    input logic                  trap_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !trap_o);

    assert_ex_bypass_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_o[1:0] == 2'd1) |->
        (ex_valid_i && ex_cls_i == 2'd1 && ex_dst_i == id_src_i[REG_W-1:0]));

    assert_mem_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid_i && id_cls_i == 2'd1 && ex_valid_i && ex_cls_i[1]
         && !(m2_valid_i && m2_exc_i)) |-> stall_o);

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_src_i[REG_W-1:0] == '0) |-> (fwd_sel_o[1:0] == 2'd0));

    assert_fault_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m2_valid_i && m2_exc_i) |-> (flush_o == 4'hF && !stall_o && !ex_rf_we_o));

    assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m2_valid_i && m2_exc_i) |=> trap_o);

    assert_trap_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(m2_valid_i && m2_exc_i) |=> !trap_o);

    assert_we_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ex_rf_we_o |-> (ex_valid_i && ex_cls_i == 2'd1 && ex_dst_i != '0));

    assert_idle_id_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid_i |-> !stall_o);
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W), .NSRC(NSRC)) u_chk (.*);

// File: tb/hazard_ctl_tb.sv
// Self-checking bench: directed corners, then a sweep over EX x M1 x ID.
module hazard_ctl_tb;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             id_valid_i;
    logic [1:0]       id_cls_i;
    logic [REG_W-1:0] src0, src1;
    logic             ex_valid_i, m1_valid_i, m2_valid_i, wb_valid_i, m2_exc_i;
    logic [1:0]       ex_cls_i, m1_cls_i, m2_cls_i, wb_cls_i;
    logic [REG_W-1:0] ex_dst_i, m1_dst_i, m2_dst_i, wb_dst_i;
    logic             stall_o, ex_rf_we_o, trap_o;
    logic [3:0]       flush_o;
    logic [2*NSRC-1:0] fwd_sel_o;

    int checks = 0;
    int failures = 0;
    bit prev_fault = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    hazard_ctl #(.REG_W(REG_W), .NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid_i(id_valid_i), .id_cls_i(id_cls_i), .id_src_i({src1, src0}),
        .ex_valid_i(ex_valid_i), .ex_cls_i(ex_cls_i), .ex_dst_i(ex_dst_i),
        .m1_valid_i(m1_valid_i), .m1_cls_i(m1_cls_i), .m1_dst_i(m1_dst_i),
        .m2_valid_i(m2_valid_i), .m2_cls_i(m2_cls_i), .m2_dst_i(m2_dst_i),
        .m2_exc_i(m2_exc_i),
        .wb_valid_i(wb_valid_i), .wb_cls_i(wb_cls_i), .wb_dst_i(wb_dst_i),
        .stall_o(stall_o), .fwd_sel_o(fwd_sel_o), .ex_rf_we_o(ex_rf_we_o),
        .flush_o(flush_o), .trap_o(trap_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear();
        id_valid_i = 1'b1; id_cls_i = 2'd1; src0 = '0; src1 = '0;
        ex_valid_i = 0; ex_cls_i = 0; ex_dst_i = 0;
        m1_valid_i = 0; m1_cls_i = 0; m1_dst_i = 0;
        m2_valid_i = 0; m2_cls_i = 0; m2_dst_i = 0; m2_exc_i = 0;
        wb_valid_i = 0; wb_cls_i = 0; wb_dst_i = 0;
    endtask

    // Expected {load_use, sel} for one source, youngest producer wins (R8).
    function automatic logic [2:0] exp_src(input logic [REG_W-1:0] s);
        logic       v [4];
        logic [1:0] c [4];
        logic [REG_W-1:0] d [4];
        logic [2:0] r;
        v[0] = ex_valid_i; c[0] = ex_cls_i; d[0] = ex_dst_i;
        v[1] = m1_valid_i; c[1] = m1_cls_i; d[1] = m1_dst_i;
        v[2] = m2_valid_i; c[2] = m2_cls_i; d[2] = m2_dst_i;
        v[3] = wb_valid_i; c[3] = wb_cls_i; d[3] = wb_dst_i;
        r = 3'b000;
        if (s != 0) begin
            for (int k = 0; k < 4; k++) begin
                if (v[k] && d[k] == s && (c[k] == 2'd1 || c[k] == 2'd2)) begin
                    if (c[k] == 2'd1) r = (k == 0) ? 3'b001 : 3'b000;
                    else if (k <= 1)  r = 3'b100;
                    else              r = (k == 2) ? 3'b010 : 3'b011;
                    break;
                end
            end
        end
        return r;
    endfunction

    task automatic check_all();
        logic [2:0] e0, e1;
        bit fault, st;
        e0 = exp_src(src0);
        e1 = exp_src(src1);
        fault = m2_valid_i && m2_exc_i;
        st = id_valid_i && !fault &&
             (e0[2] || e1[2] ||
              (id_cls_i == 2'd1 && ex_valid_i && (ex_cls_i == 2'd2 || ex_cls_i == 2'd3)));
        chk("R2/R3/R4/R7/R8 fwd0", fwd_sel_o[1:0], e0[1:0]);
        chk("R2/R3/R4/R7/R8 fwd1", fwd_sel_o[3:2], e1[1:0]);
        chk("R5/R6/R12 stall", stall_o, st);
        chk("R9 flush", flush_o, fault ? 15 : 0);
        chk("R11 ex_we", ex_rf_we_o,
            ex_valid_i && ex_cls_i == 2'd1 && ex_dst_i != 0 && !fault);
        chk("R10 trap", trap_o, prev_fault);
        prev_fault = fault;
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        clear();
        m2_valid_i = 1; m2_exc_i = 1;
        repeat (3) @(posedge clk);
        #1 chk("R1 trap in reset", trap_o, 0);
        @(negedge clk); clear(); rst_n = 1'b1;
        @(posedge clk); #1 chk("R1 trap after reset", trap_o, 0);

        // R2: ALU in EX feeds the next instruction from EX.
        @(negedge clk); clear(); ex_valid_i = 1; ex_cls_i = 1; ex_dst_i = 3; src0 = 3;
        #2 chk("R2 ex bypass", fwd_sel_o[1:0], 1); chk("R2 no stall", stall_o, 0);
        // R3: ALU in M1 is already in the register file.
        @(negedge clk); clear(); m1_valid_i = 1; m1_cls_i = 1; m1_dst_i = 3; src0 = 3;
        #2 chk("R3 m1 alu rf", fwd_sel_o[1:0], 0); chk("R3 no stall", stall_o, 0);
        // R4: load bypass from M2 and from WB.
        @(negedge clk); clear(); m2_valid_i = 1; m2_cls_i = 2; m2_dst_i = 3; src0 = 3;
        #2 chk("R4 m2 load", fwd_sel_o[1:0], 2);
        @(negedge clk); clear(); wb_valid_i = 1; wb_cls_i = 2; wb_dst_i = 3; src1 = 3;
        #2 chk("R4 wb load", fwd_sel_o[3:2], 3);
        // R5: load-use stall for a store consumer, load in EX and in M1.
        @(negedge clk); clear(); id_cls_i = 3; ex_valid_i = 1; ex_cls_i = 2; ex_dst_i = 3; src1 = 3;
        #2 chk("R5 load in ex", stall_o, 1);
        @(negedge clk); clear(); id_cls_i = 3; m1_valid_i = 1; m1_cls_i = 2; m1_dst_i = 3; src0 = 3;
        #2 chk("R5 load in m1", stall_o, 1);
        // R6: memory-after interlock, independent of dependences.
        @(negedge clk); clear(); ex_valid_i = 1; ex_cls_i = 3; src0 = 5;
        #2 chk("R6 alu behind store", stall_o, 1);
        @(negedge clk); clear(); id_cls_i = 3; ex_valid_i = 1; ex_cls_i = 3; src0 = 5;
        #2 chk("R6 store behind store", stall_o, 0);
        // R7: register 0 is never a dependence.
        @(negedge clk); clear(); id_cls_i = 3; ex_valid_i = 1; ex_cls_i = 2; ex_dst_i = 0; src0 = 0;
        #2 chk("R7 r0 load", stall_o, 0); chk("R7 r0 sel", fwd_sel_o[1:0], 0);
        // R8: youngest producer decides.
        @(negedge clk); clear(); ex_valid_i = 1; ex_cls_i = 1; ex_dst_i = 3;
        wb_valid_i = 1; wb_cls_i = 2; wb_dst_i = 3; src0 = 3;
        #2 chk("R8 ex over wb", fwd_sel_o[1:0], 1);
        @(negedge clk); clear(); m1_valid_i = 1; m1_cls_i = 1; m1_dst_i = 3;
        m2_valid_i = 1; m2_cls_i = 2; m2_dst_i = 3; src0 = 3;
        #2 chk("R8 m1 alu over m2 load", fwd_sel_o[1:0], 0); chk("R8 no stall", stall_o, 0);
        // R9/R10: fault squash, masked write, trap next cycle only.
        @(negedge clk); clear(); m2_valid_i = 1; m2_cls_i = 2; m2_exc_i = 1;
        ex_valid_i = 1; ex_cls_i = 1; ex_dst_i = 3;
        #2 chk("R9 flush", flush_o, 15); chk("R9 we masked", ex_rf_we_o, 0);
        chk("R9 no stall", stall_o, 0); chk("R10 trap not yet", trap_o, 0);
        @(negedge clk); clear();
        #2 chk("R10 trap pulse", trap_o, 1);
        @(negedge clk); clear();
        #2 chk("R10 trap ends", trap_o, 0);
        // R11: write enable with and without a nonzero destination.
        @(negedge clk); clear(); ex_valid_i = 1; ex_cls_i = 1; ex_dst_i = 3;
        #2 chk("R11 we", ex_rf_we_o, 1);
        @(negedge clk); ex_dst_i = 0;
        #2 chk("R11 we r0", ex_rf_we_o, 0);
        // R12: invalid ID or invalid producer has no effect.
        @(negedge clk); clear(); id_valid_i = 0; ex_valid_i = 1; ex_cls_i = 2; ex_dst_i = 3; src0 = 3;
        #2 chk("R12 idle id", stall_o, 0);
        @(negedge clk); clear(); ex_cls_i = 1; ex_dst_i = 3; src0 = 3;
        #2 chk("R12 invalid producer", fwd_sel_o[1:0], 0);
        @(negedge clk); clear();
        prev_fault = 1'b0;

        // Sweep: EX and M1 exhaustive over a 2-bit register space.
        for (int ex = 0; ex < 32; ex++) begin
            for (int m1 = 0; m1 < 32; m1++) begin
                for (int ic = 0; ic < 4; ic++) begin
                    for (int s0 = 0; s0 < 4; s0++) begin
                        @(negedge clk);
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        ex_valid_i = ex[4]; ex_cls_i = ex[3:2]; ex_dst_i = REG_W'(ex[1:0]);
                        m1_valid_i = m1[4]; m1_cls_i = m1[3:2]; m1_dst_i = REG_W'(m1[1:0]);
                        id_cls_i = ic[1:0]; src0 = REG_W'(s0);
                        id_valid_i = (lfsr[2:0] != 0);
                        src1 = REG_W'(lfsr[4:3]);
                        m2_valid_i = lfsr[5]; m2_cls_i = lfsr[7:6]; m2_dst_i = REG_W'(lfsr[9:8]);
                        m2_exc_i = (lfsr[13:10] == 0);
                        wb_valid_i = lfsr[14]; wb_cls_i = {lfsr[15], lfsr[0]};
                        wb_dst_i = REG_W'({lfsr[1], lfsr[11]});
                        #2 check_all();
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule